// File: doc/BRIEF.md
# Mode-Banked Processor Register File

This block is the general register file of a 32-bit processor core. The core sees sixteen architectural registers at every moment: indices 0 to 13 are general purpose, index 13 is the stack pointer by convention, index 14 holds the return link and index 15 is the program counter. Which physical register answers a given index depends on the operating mode the core is running in. The fast-interrupt mode has private copies of indices 8 to 14. The interrupt, supervisor, abort and undefined modes each have private copies of indices 13 and 14 only. User and system modes use the shared set. A register that a mode switch hides keeps its value until that mode is entered again.

The file has two combinational read ports and one synchronous write port. It also has a call strobe that copies the current program counter into the active mode's index-14 register. A further input selects word-aligned or halfword-aligned instruction state, and this sets which low bits of the program counter read as zero. Each privileged mode that has its own entry reason also has one saved-status register. That register is reached through a separate read and write pair and only works while its mode is active.

Top module: `banked_regfile`

## Requirements
- R1: After synchronous reset, every physical register and every saved-status register holds zero, so every index reads zero in every mode.
- R2: Mode codes 10000 (user) and 11111 (system) address exactly the same physical registers for all sixteen indices.
- R3: In mode 10001 (fast interrupt), indices 8 to 14 select seven private registers. Indices 0 to 7 and 15 select the shared set.
- R4: In modes 10010, 10011, 10111 and 11011 (interrupt, supervisor, abort, undefined), indices 13 and 14 select a private pair for each mode. Indices 0 to 12 and 15 select the shared set.
- R5: A register keeps the value last written to it across any sequence of mode changes. A cycle with no write and no call strobe changes no register.
- R6: Any mode code not listed in R2 to R4 behaves exactly like user mode.
- R7: When the call strobe is high at a rising edge, the program-counter value as currently read (with masking per R9) is stored in index 14 of the current mode's bank.
- R8: If the call strobe and a port write to index 14 of the same bank fall in the same cycle, the stored value is the captured program counter.
- R9: A read of index 15 returns the stored value with bits [1:0] cleared when the halfword input is 0, and with bit [0] cleared when it is 1. Reads of other indices are never masked.
- R10: A port write takes effect at the rising edge. A read of the same index in that same cycle returns the previous value.
- R11: Each of the five privileged modes other than system has its own saved-status register. In user or system mode (or an unrecognised code) the saved-status read returns zero and a saved-status write changes nothing.
- R12: The two read ports select their indices independently and may read any two indices in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| mode_i | input | 5 | Current operating mode code |
| half_i | input | 1 | 1 = halfword instruction alignment, 0 = word alignment |
| rda_idx | input | 4 | Read port A architectural index |
| rda_data | output | DATA_W | Read port A data |
| rdb_idx | input | 4 | Read port B architectural index |
| rdb_data | output | DATA_W | Read port B data |
| wr_en | input | 1 | Write enable for the write port |
| wr_idx | input | 4 | Write port architectural index |
| wr_data | input | DATA_W | Write port data |
| call_link_i | input | 1 | Capture the program counter into the current bank's index 14 |
| ss_wr_en | input | 1 | Saved-status write enable |
| ss_wr_data | input | SR_W | Saved-status write data |
| ss_rd_data | output | SR_W | Saved-status read data for the current mode |

## Verification
The assertions check several properties on every cycle. A call strobe lands its program-counter value, and it takes priority over a colliding port write. An uncontested write reaches its physical register, and an idle cycle leaves all storage unchanged. Program-counter reads carry the right low-bit masking, and the saved-status path reads zero and ignores writes outside the privileged modes. The assertions work in physical addresses, so only the bench's scenarios can show that each mode maps each index to the right physical register. The bench scenarios also show that values stay isolated between banks, that system mode and unknown codes alias the user set, and that a same-cycle read sees the old value.

// File: rtl/rf_bank_pkg.sv
package rf_bank_pkg;

    localparam int IDX_W       = 4;
    localparam int ARCH_REGS   = 1 << IDX_W;
    localparam int SP_IDX      = 13;
    localparam int LR_IDX      = 14;
    localparam int PC_IDX      = 15;
    localparam int FIQ_FIRST   = 8;
    localparam int FIQ_REGS    = LR_IDX - FIQ_FIRST + 1;
    localparam int PAIR_BANKS  = 4;
    localparam int PAIR_REGS   = LR_IDX - SP_IDX + 1;
    localparam int SHARED_REGS = ARCH_REGS;
    localparam int PAIR_BASE   = SHARED_REGS + FIQ_REGS;
    localparam int PHYS_REGS   = PAIR_BASE + PAIR_BANKS * PAIR_REGS;
    localparam int PHYS_W      = $clog2(PHYS_REGS);
    localparam int NUM_SAVED   = 1 + PAIR_BANKS;
    localparam int SAV_W       = $clog2(NUM_SAVED);

    localparam logic [4:0] MD_USR = 5'b10000;
    localparam logic [4:0] MD_FIQ = 5'b10001;
    localparam logic [4:0] MD_IRQ = 5'b10010;
    localparam logic [4:0] MD_SVC = 5'b10011;
    localparam logic [4:0] MD_ABT = 5'b10111;
    localparam logic [4:0] MD_UND = 5'b11011;
    localparam logic [4:0] MD_SYS = 5'b11111;

    // Bank identity; order matters for the pair-bank and saved-status offsets.
    typedef enum logic [2:0] {
        BK_USR = 3'd0,
        BK_FIQ = 3'd1,
        BK_IRQ = 3'd2,
        BK_SVC = 3'd3,
        BK_ABT = 3'd4,
        BK_UND = 3'd5
    } bank_e;

    function automatic bank_e decode_mode(logic [4:0] code);
        case (code)
            MD_FIQ:  return BK_FIQ;
            MD_IRQ:  return BK_IRQ;
            MD_SVC:  return BK_SVC;
            MD_ABT:  return BK_ABT;
            MD_UND:  return BK_UND;
            default: return BK_USR;   // user, system and unknown codes
        endcase
    endfunction

    function automatic logic [PHYS_W-1:0] phys_index(bank_e b, logic [IDX_W-1:0] idx);
        int r;
        r = int'(idx);
        if (b == BK_FIQ && idx >= IDX_W'(FIQ_FIRST) && idx <= IDX_W'(LR_IDX))
            r = SHARED_REGS + int'(idx) - FIQ_FIRST;
        else if (b != BK_USR && b != BK_FIQ && idx >= IDX_W'(SP_IDX) && idx <= IDX_W'(LR_IDX))
            r = PAIR_BASE + PAIR_REGS * (int'(b) - int'(BK_IRQ)) + int'(idx) - SP_IDX;
        return PHYS_W'(r);
    endfunction

endpackage

// File: rtl/rf_mode_decode.sv
module rf_mode_decode
    import rf_bank_pkg::*;
(
    input  logic [4:0] mode_code,
    output bank_e      bank
);
    assign bank = decode_mode(mode_code);
endmodule

// File: rtl/rf_index_map.sv
module rf_index_map
    import rf_bank_pkg::*;
(
    input  bank_e             bank,
    input  logic [IDX_W-1:0]  arch_idx,
    output logic [PHYS_W-1:0] phys_idx
);
    assign phys_idx = phys_index(bank, arch_idx);
endmodule

// File: rtl/rf_storage.sv
module rf_storage
    import rf_bank_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int DEPTH  = PHYS_REGS
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [PHYS_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              lk_en,
    input  logic [PHYS_W-1:0] lk_addr,
    input  logic [DATA_W-1:0] lk_data,
    input  logic [PHYS_W-1:0] rd_a_addr,
    output logic [DATA_W-1:0] rd_a_data,
    input  logic [PHYS_W-1:0] rd_b_addr,
    output logic [DATA_W-1:0] rd_b_data,
    output logic [DATA_W-1:0] pc_raw
);
    logic [DEPTH-1:0][DATA_W-1:0] mem_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            mem_q <= '0;
        end else begin
            for (int p = 0; p < DEPTH; p++) begin
                if (lk_en && lk_addr == PHYS_W'(p))
                    mem_q[p] <= lk_data;
                else if (wr_en && wr_addr == PHYS_W'(p))
                    mem_q[p] <= wr_data;
            end
        end
    end

    assign rd_a_data = mem_q[rd_a_addr];
    assign rd_b_data = mem_q[rd_b_addr];
    assign pc_raw    = mem_q[PC_IDX];

    a_r7_link_lands: assert property (@(posedge clk) disable iff (rst)
        lk_en |=> mem_q[$past(lk_addr)] == $past(lk_data));

    a_r8_link_beats_write: assert property (@(posedge clk) disable iff (rst)
        (lk_en && wr_en && lk_addr == wr_addr && wr_data != lk_data)
        |=> mem_q[$past(wr_addr)] != $past(wr_data));

    a_r10_write_lands: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !(lk_en && lk_addr == wr_addr))
        |=> mem_q[$past(wr_addr)] == $past(wr_data));

    a_r5_idle_holds: assert property (@(posedge clk) disable iff (rst)
        (!wr_en && !lk_en) |=> $stable(mem_q));
endmodule

// File: rtl/rf_saved_status.sv
module rf_saved_status
    import rf_bank_pkg::*;
#(
    parameter int SR_W = 32
) (
    input  logic            clk,
    input  logic            rst,
    input  bank_e           bank,
    input  logic            wr_en,
    input  logic [SR_W-1:0] wr_data,
    output logic [SR_W-1:0] rd_data
);
    logic [NUM_SAVED-1:0][SR_W-1:0] sr_q;
    logic [SAV_W-1:0]               sel;
    logic                           has_sr;

    assign has_sr = (bank != BK_USR);
    assign sel    = SAV_W'(int'(bank) - 1);

    always_ff @(posedge clk) begin
        if (rst)
            sr_q <= '0;
        else if (wr_en && has_sr)
            sr_q[sel] <= wr_data;
    end

    assign rd_data = has_sr ? sr_q[sel] : '0;

    a_r11_user_reads_zero: assert property (@(posedge clk) disable iff (rst)
        (bank == BK_USR) |-> rd_data == '0);

    a_r11_user_write_ignored: assert property (@(posedge clk) disable iff (rst)
        (bank == BK_USR) |=> $stable(sr_q));
endmodule

// File: rtl/banked_regfile.sv
module banked_regfile
    import rf_bank_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int SR_W   = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [4:0]        mode_i,
    input  logic              half_i,
    input  logic [3:0]        rda_idx,
    output logic [DATA_W-1:0] rda_data,
    input  logic [3:0]        rdb_idx,
    output logic [DATA_W-1:0] rdb_data,
    input  logic              wr_en,
    input  logic [3:0]        wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              call_link_i,
    input  logic              ss_wr_en,
    input  logic [SR_W-1:0]   ss_wr_data,
    output logic [SR_W-1:0]   ss_rd_data
);
    localparam int LOOKUPS = 4;
    localparam int LU_RDA  = 0;
    localparam int LU_RDB  = 1;
    localparam int LU_WR   = 2;
    localparam int LU_LR   = 3;

    bank_e             cur_bank;
    logic [IDX_W-1:0]  lu_idx  [LOOKUPS];
    logic [PHYS_W-1:0] lu_phys [LOOKUPS];
    logic [DATA_W-1:0] raw_a, raw_b, pc_raw, pc_cur;

    function automatic logic [DATA_W-1:0] pc_align(logic [DATA_W-1:0] v, logic half);
        logic [DATA_W-1:0] r;
        r = v;
        r[0] = 1'b0;
        if (!half) r[1] = 1'b0;
        return r;
    endfunction

    rf_mode_decode u_dec (.mode_code(mode_i), .bank(cur_bank));

    assign lu_idx[LU_RDA] = rda_idx;
    assign lu_idx[LU_RDB] = rdb_idx;
    assign lu_idx[LU_WR]  = wr_idx;
    assign lu_idx[LU_LR]  = IDX_W'(LR_IDX);

    for (genvar g = 0; g < LOOKUPS; g++) begin : g_map
        rf_index_map u_map (
            .bank     (cur_bank),
            .arch_idx (lu_idx[g]),
            .phys_idx (lu_phys[g])
        );
    end

    rf_storage #(.DATA_W(DATA_W)) u_store (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_addr   (lu_phys[LU_WR]),
        .wr_data   (wr_data),
        .lk_en     (call_link_i),
        .lk_addr   (lu_phys[LU_LR]),
        .lk_data   (pc_cur),
        .rd_a_addr (lu_phys[LU_RDA]),
        .rd_a_data (raw_a),
        .rd_b_addr (lu_phys[LU_RDB]),
        .rd_b_data (raw_b),
        .pc_raw    (pc_raw)
    );

    assign pc_cur   = pc_align(pc_raw, half_i);
    assign rda_data = (rda_idx == IDX_W'(PC_IDX)) ? pc_align(raw_a, half_i) : raw_a;
    assign rdb_data = (rdb_idx == IDX_W'(PC_IDX)) ? pc_align(raw_b, half_i) : raw_b;

    rf_saved_status #(.SR_W(SR_W)) u_saved (
        .clk     (clk),
        .rst     (rst),
        .bank    (cur_bank),
        .wr_en   (ss_wr_en),
        .wr_data (ss_wr_data),
        .rd_data (ss_rd_data)
    );

    a_r9_word_pc_mask: assert property (@(posedge clk) disable iff (rst)
        (rda_idx == IDX_W'(PC_IDX) && !half_i) |-> rda_data[1:0] == 2'b00);

    a_r9_half_pc_mask: assert property (@(posedge clk) disable iff (rst)
        (rdb_idx == IDX_W'(PC_IDX) && half_i) |-> rdb_data[0] == 1'b0);
endmodule

// File: tb/banked_regfile_bench.sv
`timescale 1ns/1ps
module banked_regfile_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [4:0]  mode_i = 5'b10000;
    logic        half_i = 1'b0;
    logic [3:0]  rda_idx = '0, rdb_idx = '0, wr_idx = '0;
    logic [31:0] rda_data, rdb_data, wr_data = '0;
    logic        wr_en = 1'b0, call_link_i = 1'b0, ss_wr_en = 1'b0;
    logic [31:0] ss_wr_data = '0, ss_rd_data;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    // Mode codes from the requirements: usr, fiq, irq, svc, abt, und, sys
    localparam logic [4:0] MODES [7] = '{5'b10000, 5'b10001, 5'b10010, 5'b10011,
                                         5'b10111, 5'b11011, 5'b11111};

    // Reference model of the banks
    logic [31:0] m_usr [16];
    logic [31:0] m_fiq [7];
    logic [31:0] m_pair [4][2];
    logic [31:0] m_ss [5];

    always #2.5 clk = ~clk;

    banked_regfile u_banked_regfile (
        .clk, .rst, .mode_i, .half_i, .rda_idx, .rda_data, .rdb_idx, .rdb_data,
        .wr_en, .wr_idx, .wr_data, .call_link_i, .ss_wr_en, .ss_wr_data, .ss_rd_data
    );

    function automatic int bank_of(logic [4:0] m);
        case (m)
            5'b10001: return 1;
            5'b10010: return 2;
            5'b10011: return 3;
            5'b10111: return 4;
            5'b11011: return 5;
            default:  return 0;
        endcase
    endfunction

    function automatic logic [31:0] m_read(logic [4:0] m, int i, logic half);
        int b = bank_of(m);
        logic [31:0] v;
        if (b == 1 && i >= 8 && i <= 14) v = m_fiq[i-8];
        else if (b >= 2 && (i == 13 || i == 14)) v = m_pair[b-2][i-13];
        else v = m_usr[i];
        if (i == 15) v = half ? {v[31:1], 1'b0} : {v[31:2], 2'b00};
        return v;
    endfunction

    task automatic m_write(logic [4:0] m, int i, logic [31:0] d);
        int b = bank_of(m);
        if (b == 1 && i >= 8 && i <= 14) m_fiq[i-8] = d;
        else if (b >= 2 && (i == 13 || i == 14)) m_pair[b-2][i-13] = d;
        else m_usr[i] = d;
    endtask

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_write(logic [4:0] m, int i, logic [31:0] d);
        @(negedge clk);
        mode_i = m; wr_idx = 4'(i); wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
        m_write(m, i, d);
    endtask

    task automatic read_pair(string req, logic [4:0] m, logic half, int a, int b);
        mode_i = m; half_i = half; rda_idx = 4'(a); rdb_idx = 4'(b);
        #0.5;
        chk(req, rda_data, m_read(m, a, half));
        chk(req, rdb_data, m_read(m, b, half));
    endtask

    task automatic sweep(string req);
        foreach (MODES[k])
            for (int i = 0; i < 16; i++)
                read_pair(req, MODES[k], 1'b0, i, 15 - i);
    endtask

    task automatic t_reset();
        sweep("R1");
        foreach (MODES[k]) begin
            mode_i = MODES[k]; #0.5;
            chk("R1 saved", ss_rd_data, 32'h0);
        end
    endtask

    task automatic t_fill();
        foreach (MODES[k])
            for (int i = 0; i < 16; i++)
                do_write(MODES[k], i, {8'hA0 + 8'(k), 16'h5A00, 4'h0, 4'(i)} | ((i == 15) ? 32'h3 : 32'h0));
        sweep("R3 R4 R12");
        do_write(5'b11111, 13, 32'h5151_0013);
        read_pair("R2", 5'b10000, 1'b0, 13, 14);
        chk("R2", rda_data, 32'h5151_0013);
        do_write(5'b10001, 7, 32'h0F1F_0007);
        read_pair("R3", 5'b10000, 1'b0, 7, 8);
        chk("R3", rda_data, 32'h0F1F_0007);
        read_pair("R4", 5'b10011, 1'b0, 12, 13);
        chk("R4", rdb_data, m_pair[1][0]);
    endtask

    task automatic t_unknown();
        do_write(5'b10100, 13, 32'hDEAD_0613);
        read_pair("R6", 5'b10000, 1'b0, 13, 14);
        chk("R6", rda_data, 32'hDEAD_0613);
        read_pair("R6", 5'b00000, 1'b0, 14, 13);
        chk("R6", rdb_data, 32'hDEAD_0613);
    endtask

    task automatic t_pcmask();
        do_write(5'b10000, 15, 32'h1234_5677);
        do_write(5'b10000, 3, 32'h0000_0333);
        read_pair("R9", 5'b10000, 1'b0, 15, 3);
        chk("R9 word", rda_data, 32'h1234_5674);
        chk("R9 unmasked", rdb_data, 32'h0000_0333);
        read_pair("R9", 5'b10000, 1'b1, 3, 15);
        chk("R9 half", rdb_data, 32'h1234_5676);
    endtask

    task automatic t_link();
        @(negedge clk);
        mode_i = 5'b10011; half_i = 1'b0; call_link_i = 1'b1;
        @(negedge clk);
        call_link_i = 1'b0;
        m_pair[1][1] = 32'h1234_5674;
        read_pair("R7", 5'b10011, 1'b0, 14, 15);
        chk("R7", rda_data, 32'h1234_5674);
        read_pair("R7", 5'b10000, 1'b0, 14, 13);
        // Call strobe collides with port write to index 14 in fast-interrupt mode
        @(negedge clk);
        mode_i = 5'b10001; half_i = 1'b1; call_link_i = 1'b1;
        wr_en = 1'b1; wr_idx = 4'd14; wr_data = 32'hBAD0_BAD0;
        @(negedge clk);
        call_link_i = 1'b0; wr_en = 1'b0;
        m_fiq[6] = 32'h1234_5676;
        read_pair("R8", 5'b10001, 1'b1, 14, 9);
        chk("R8", rda_data, 32'h1234_5676);
    endtask

    task automatic t_nowt();
        @(negedge clk);
        mode_i = 5'b10000; half_i = 1'b0; rda_idx = 4'd5; rdb_idx = 4'd5;
        wr_en = 1'b1; wr_idx = 4'd5; wr_data = 32'h7777_0005;
        #0.5;
        chk("R10 old", rda_data, m_read(5'b10000, 5, 1'b0));
        @(negedge clk);
        wr_en = 1'b0;
        m_write(5'b10000, 5, 32'h7777_0005);
        read_pair("R10 new", 5'b10000, 1'b0, 5, 0);
    endtask

    task automatic t_saved();
        for (int k = 1; k <= 5; k++) begin
            @(negedge clk);
            mode_i = MODES[k]; ss_wr_en = 1'b1; ss_wr_data = 32'h5500_0000 + 32'(k);
            @(negedge clk);
            ss_wr_en = 1'b0;
            m_ss[k-1] = 32'h5500_0000 + 32'(k);
        end
        foreach (MODES[k]) begin
            if (k == 0 || k == 6) continue;
            @(negedge clk);
            ss_wr_en = 1'b1; ss_wr_data = 32'hFFFF_FFFF; mode_i = MODES[k == 1 ? 0 : 6];
            #0.5;
            chk("R11 user read", ss_rd_data, 32'h0);
            @(negedge clk);
            ss_wr_en = 1'b0;
        end
        for (int k = 1; k <= 5; k++) begin
            mode_i = MODES[k]; #0.5;
            chk("R11 kept", ss_rd_data, m_ss[k-1]);
        end
        mode_i = 5'b11111; #0.5;
        chk("R11 sys read", ss_rd_data, 32'h0);
    endtask

    task automatic t_revisit();
        sweep("R5");
    endtask

    initial begin
        foreach (m_usr[i]) m_usr[i] = '0;
        foreach (m_fiq[i]) m_fiq[i] = '0;
        for (int b = 0; b < 4; b++) begin m_pair[b][0] = '0; m_pair[b][1] = '0; end
        foreach (m_ss[i]) m_ss[i] = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_fill();
        t_unknown();
        t_pcmask();
        t_link();
        t_nowt();
        t_saved();
        t_revisit();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule